// File: doc/BRIEF.md
# Circular Packet Buffer Pointer Manager

This block keeps the pointers of one channel's circular packet buffer in a byte-addressed memory. Software loads an inclusive window (a 32-byte aligned base and a top address) and, from then on, the block owns the write pointer. Each accepted record request produces a burst of write strobes with the byte address of every 8-byte beat of one fixed-stride record. The write pointer moves forward by one stride when the burst ends, and returns to base when the next record would no longer fit below top+1.

A consumer moves the read pointer by writing it. A written value of top+1 stands for the end of the window and is stored as base. The block compares the two pointers and reports how many complete records can be read without crossing the end of the window. A record that would make the write pointer equal to the read pointer is refused and flagged as an overflow.

Shutdown uses a per-channel enable and an idle request. An idle request is a write carrying a request flag and a per-channel bit. While it is pending, no new record starts. The acknowledge rises once any record in progress has finished. Writing a value without both bits removes the request.

Top module: `cpb_pointer_mgr`

## Requirements
- R1: After reset, wr_ptr, rd_ptr and avail_pkts are 0, and wr_stb, overflow and idle_ack are low.
- R2: A cfg_load pulse stores cfg_top and stores cfg_base with its low 5 bits cleared. It sets both pointers to that aligned base and abandons any record in progress, so wr_stb is low in the next cycle.
- R3: The record stride is 192 bytes, which is 188 + 4 rounded up to a multiple of 8. An accepted rec_start produces wr_stb for exactly 24 consecutive cycles, starting the cycle after acceptance, with wr_addr = wr_ptr + 8*k on beat k.
- R4: When the burst ends, wr_ptr becomes wr_ptr+192. If that address plus 192 would exceed top+1, wr_ptr becomes base instead. wr_ptr does not change during a burst.
- R5: If the advanced write pointer (per R4) equals rd_ptr, the rec_start is refused. No strobe follows, wr_ptr does not change, and overflow is high for one cycle, the cycle after the request.
- R6: An rp_wr pulse sets rd_ptr to rp_wdata in the next cycle, except that a value of top+1 sets rd_ptr to base.
- R7: avail_pkts is (wr_ptr - rd_ptr)/192 when wr_ptr >= rd_ptr, and (top+1 - rd_ptr)/192 otherwise. It updates in the cycle after a pointer changes.
- R8: rec_start is ignored while chan_en is 0 and while a record is in progress. No strobe and no overflow result.
- R9: idle_wdata has the request flag at bit NUM_CH and the channel bit at bit CH_ID. A write with both bits set makes the request pending. idle_ack is high while a request is pending and no record is in progress, and records are refused while a request is pending.
- R10: An idle write without both bits set (for example zero) clears the pending request, and idle_ack is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load window and reset both pointers |
| cfg_base | input | ADDR_W | Window base (low 5 bits ignored) |
| cfg_top | input | ADDR_W | Window top, inclusive |
| chan_en | input | 1 | Channel enable for new records |
| rec_start | input | 1 | Request to write one record |
| rp_wr | input | 1 | Read pointer update strobe |
| rp_wdata | input | ADDR_W | New read pointer |
| idle_wr | input | 1 | Idle request register write strobe |
| idle_wdata | input | NUM_CH+1 | Channel bits plus request flag in the top bit |
| wr_stb | output | 1 | Write beat strobe |
| wr_addr | output | ADDR_W | Byte address of the current beat |
| wr_ptr | output | ADDR_W | Write pointer |
| rd_ptr | output | ADDR_W | Read pointer |
| avail_pkts | output | ADDR_W | Complete records readable before the window end |
| overflow | output | 1 | One-cycle pulse on a refused record |
| idle_ack | output | 1 | Channel idle with request pending |

## Verification
A wrong pointer shows up within one burst. The first strobe of the next record lands at a wrong address, or avail_pkts is off right after the pointer update. A wrong wrap decision shows up when the window is filled, as a wrong refusal point or as a strobe outside the window. A stuck busy or pending state shows up as idle_ack being too early or too late, measured against the 24-beat burst length. To expose these faults, the bench sweeps every combination of read position and record count over a window of eight records, with and without slack at the top of the window.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  localparam int BASE_ALIGN_BYTES = 32;

  function automatic int round_up(input int value, input int multiple);
    return ((value + multiple - 1) / multiple) * multiple;
  endfunction
endpackage

// File: rtl/cpb_rec_writer.sv
module cpb_rec_writer #(
  parameter int ADDR_W     = 32,
  parameter int STRIDE     = 192,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] new_base,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [ADDR_W-1:0] top_q,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic              start_req,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              busy,
  output logic              ovf
);
  localparam int BEATS  = STRIDE / BEAT_BYTES;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [ADDR_W:0]   STRIDE_X = (ADDR_W+1)'(STRIDE);
  localparam logic [ADDR_W-1:0] BEAT_A   = ADDR_W'(BEAT_BYTES);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [ADDR_W-1:0] wp_q, wp_d, addr_q, addr_d, wp_next;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              busy_q, busy_d, ovf_q, ovf_d;
  logic              wp_en, addr_en, beat_en;
  logic [ADDR_W:0]   adv_x, end_x;
  logic              fits, full, accept, last_beat;

  always_comb begin
    adv_x   = {1'b0, wp_q} + STRIDE_X;
    end_x   = {1'b0, top_q} + (ADDR_W+1)'(1);
    fits    = (adv_x + STRIDE_X) <= end_x;
    wp_next = fits ? adv_x[ADDR_W-1:0] : base_q;
    full    = (wp_next == rd_ptr);
    accept  = start_req & ~busy_q & ~full & ~cfg_load;
    last_beat = busy_q & (beat_q == LAST_BEAT);
  end

  always_comb begin
    wp_d    = wp_q;
    addr_d  = addr_q;
    beat_d  = beat_q;
    busy_d  = busy_q;
    wp_en   = 1'b0;
    addr_en = 1'b0;
    beat_en = 1'b0;
    ovf_d   = start_req & ~busy_q & full & ~cfg_load;
    if (cfg_load) begin
      wp_d = new_base;  wp_en = 1'b1;
      addr_d = new_base; addr_en = 1'b1;
      beat_d = '0;       beat_en = 1'b1;
      busy_d = 1'b0;
    end else if (accept) begin
      addr_d = wp_q;     addr_en = 1'b1;
      beat_d = '0;       beat_en = 1'b1;
      busy_d = 1'b1;
    end else if (busy_q) begin
      addr_d = addr_q + BEAT_A; addr_en = 1'b1;
      beat_d = beat_q + BEAT_W'(1); beat_en = 1'b1;
      if (last_beat) begin
        busy_d = 1'b0;
        wp_d   = wp_next;
        wp_en  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      addr_q <= '0;
      beat_q <= '0;
      busy_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (wp_en)   wp_q   <= wp_d;
      if (addr_en) addr_q <= addr_d;
      if (beat_en) beat_q <= beat_d;
      busy_q <= busy_d;
      ovf_q  <= ovf_d;
    end
  end

  assign wr_ptr  = wp_q;
  assign wr_addr = addr_q;
  assign busy    = busy_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/cpb_rd_ptr.sv
module cpb_rd_ptr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] new_base,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [ADDR_W-1:0] top_q,
  input  logic              rp_wr,
  input  logic [ADDR_W-1:0] rp_wdata,
  output logic [ADDR_W-1:0] rd_ptr
);
  logic [ADDR_W-1:0] rp_q, rp_d;
  logic              rp_en;

  always_comb begin
    rp_en = cfg_load | rp_wr;
    if (cfg_load)                            rp_d = new_base;
    else if (rp_wdata == top_q + ADDR_W'(1)) rp_d = base_q;
    else                                     rp_d = rp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rp_q <= '0;
    else if (rp_en) rp_q <= rp_d;
  end

  assign rd_ptr = rp_q;
endmodule

// File: rtl/cpb_level.sv
module cpb_level #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 192
) (
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic [ADDR_W-1:0] top_q,
  output logic [ADDR_W-1:0] avail_pkts
);
  localparam logic [ADDR_W:0] STRIDE_X = (ADDR_W+1)'(STRIDE);

  logic [ADDR_W:0] span, quot;

  always_comb begin
    if (wr_ptr >= rd_ptr) span = {1'b0, wr_ptr} - {1'b0, rd_ptr};
    else                  span = {1'b0, top_q} + (ADDR_W+1)'(1) - {1'b0, rd_ptr};
    quot       = span / STRIDE_X;
    avail_pkts = quot[ADDR_W-1:0];
  end
endmodule

// File: rtl/cpb_idle_ctl.sv
module cpb_idle_ctl #(
  parameter int NUM_CH = 4,
  parameter int CH_ID  = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_wr,
  input  logic [NUM_CH:0] idle_wdata,
  input  logic            busy,
  output logic            pending,
  output logic            idle_ack
);
  localparam logic [NUM_CH:0] SEL_MASK =
    (NUM_CH+1)'((1 << NUM_CH) | (1 << CH_ID));

  logic pend_q, pend_d;

  assign pend_d = ((idle_wdata & SEL_MASK) == SEL_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (idle_wr) pend_q <= pend_d;
  end

  assign pending  = pend_q;
  assign idle_ack = pend_q & ~busy;
endmodule

// File: rtl/cpb_pointer_mgr.sv
module cpb_pointer_mgr #(
  parameter int ADDR_W     = 32,
  parameter int PKT_BYTES  = 188,
  parameter int HDR_BYTES  = 4,
  parameter int REC_ALIGN  = 8,
  parameter int BEAT_BYTES = 8,
  parameter int NUM_CH     = 4,
  parameter int CH_ID      = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_top,
  input  logic              chan_en,
  input  logic              rec_start,
  input  logic              rp_wr,
  input  logic [ADDR_W-1:0] rp_wdata,
  input  logic              idle_wr,
  input  logic [NUM_CH:0]   idle_wdata,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] avail_pkts,
  output logic              overflow,
  output logic              idle_ack
);
  localparam int STRIDE = cpb_pkg::round_up(PKT_BYTES + HDR_BYTES, REC_ALIGN);
  localparam logic [ADDR_W-1:0] ALIGN_MASK =
    ~ADDR_W'(cpb_pkg::BASE_ALIGN_BYTES - 1);

  logic              rst_meta, rst_sync;
  logic [ADDR_W-1:0] base_q, top_q, new_base;
  logic              busy, pending, start_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign new_base = cfg_base & ALIGN_MASK;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      base_q <= '0;
      top_q  <= '0;
    end else if (cfg_load) begin
      base_q <= new_base;
      top_q  <= cfg_top;
    end
  end

  assign start_req = rec_start & chan_en & ~pending;

  cpb_rec_writer #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .BEAT_BYTES(BEAT_BYTES)) u_writer (
    .clk(clk), .rst_n(rst_sync), .cfg_load(cfg_load), .new_base(new_base),
    .base_q(base_q), .top_q(top_q), .rd_ptr(rd_ptr), .start_req(start_req),
    .wr_ptr(wr_ptr), .wr_addr(wr_addr), .busy(busy), .ovf(overflow)
  );

  cpb_rd_ptr #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_sync), .cfg_load(cfg_load), .new_base(new_base),
    .base_q(base_q), .top_q(top_q), .rp_wr(rp_wr), .rp_wdata(rp_wdata),
    .rd_ptr(rd_ptr)
  );

  cpb_level #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_level (
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .top_q(top_q), .avail_pkts(avail_pkts)
  );

  cpb_idle_ctl #(.NUM_CH(NUM_CH), .CH_ID(CH_ID)) u_idle (
    .clk(clk), .rst_n(rst_sync), .idle_wr(idle_wr), .idle_wdata(idle_wdata),
    .busy(busy), .pending(pending), .idle_ack(idle_ack)
  );

  assign wr_stb = busy;
endmodule

// File: rtl/cpb_pointer_mgr_chk.sv
module cpb_pointer_mgr_chk #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] top_q,
  input logic              overflow,
  input logic              idle_ack
);
  assert_stb_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr >= base_q && wr_addr <= top_q));

  assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |-> wr_addr == wr_ptr);

  assert_beat_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && $past(wr_stb)) |-> wr_addr == $past(wr_addr) + ADDR_W'(BEAT_BYTES));

  assert_wp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && $past(wr_stb)) |-> $stable(wr_ptr));

  assert_no_stb_on_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !wr_stb);

  assert_rp_end_folded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr != top_q + ADDR_W'(1));

  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |-> $past(chan_en));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ack |-> !wr_stb);
endmodule

bind cpb_pointer_mgr cpb_pointer_mgr_chk #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .base_q(base_q), .top_q(top_q),
  .overflow(overflow), .idle_ack(idle_ack)
);

// File: tb/cpb_pointer_mgr_test.sv
module cpb_pointer_mgr_test;
  localparam int AW = 32;
  localparam int NCH = 4;
  localparam int CH = 2;
  localparam int STR = 192;
  localparam int BEATS = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_top = '0;
  logic chan_en = 1'b0, rec_start = 1'b0, rp_wr = 1'b0, idle_wr = 1'b0;
  logic [AW-1:0] rp_wdata = '0;
  logic [NCH:0] idle_wdata = '0;
  logic wr_stb, overflow, idle_ack;
  logic [AW-1:0] wr_addr, wr_ptr, rd_ptr, avail_pkts;

  int n_checks = 0;
  int n_fail = 0;
  logic [AW-1:0] m_base, m_top, m_wp, m_rp;
  logic m_en = 1'b0, m_pend = 1'b0;

  always #4 clk = ~clk;

  cpb_pointer_mgr #(.ADDR_W(AW), .NUM_CH(NCH), .CH_ID(CH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_top(cfg_top), .chan_en(chan_en), .rec_start(rec_start), .rp_wr(rp_wr),
    .rp_wdata(rp_wdata), .idle_wr(idle_wr), .idle_wdata(idle_wdata),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .avail_pkts(avail_pkts), .overflow(overflow), .idle_ack(idle_ack)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] wp);
    logic [AW:0] a;
    a = {1'b0, wp} + STR;
    if (a + STR > {1'b0, m_top} + 1) return m_base;
    return a[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] f_avail();
    if (m_wp >= m_rp) return (m_wp - m_rp) / STR;
    return (m_top + 1 - m_rp) / STR;
  endfunction

  task automatic do_cfg(input logic [AW-1:0] base, input logic [AW-1:0] top);
    @(negedge clk);
    cfg_load = 1'b1; cfg_base = base; cfg_top = top;
    @(negedge clk);
    cfg_load = 1'b0;
    m_base = base & ~32'h1F; m_top = top; m_wp = m_base; m_rp = m_base;
  endtask

  task automatic wr_rp(input logic [AW-1:0] v);
    @(negedge clk);
    rp_wr = 1'b1; rp_wdata = v;
    @(negedge clk);
    rp_wr = 1'b0;
    m_rp = (v == m_top + 1) ? m_base : v;
    check("R6 rd_ptr after write", rd_ptr, m_rp);
    check("R7 avail after rd write", avail_pkts, f_avail());
  endtask

  task automatic push(input string tag);
    logic acc, ovf_exp;
    int bad;
    acc = m_en && !m_pend && (adv(m_wp) != m_rp);
    ovf_exp = m_en && !m_pend && (adv(m_wp) == m_rp);
    @(negedge clk);
    rec_start = 1'b1;
    @(negedge clk);
    rec_start = 1'b0;
    if (acc) begin
      bad = 0;
      for (int b = 0; b < BEATS; b++) begin
        if (!wr_stb || wr_addr !== m_wp + AW'(8 * b)) bad++;
        @(negedge clk);
      end
      check({tag, " R3 burst beats/addresses"}, AW'(bad), 0);
      check({tag, " R3 strobe ends after 24 beats"}, AW'(wr_stb), 0);
      m_wp = adv(m_wp);
      check({tag, " R4 wr_ptr advance"}, wr_ptr, m_wp);
    end else begin
      check({tag, " R5/R8 overflow flag"}, AW'(overflow), AW'(ovf_exp));
      check({tag, " R5/R8 no strobe"}, AW'(wr_stb), 0);
      @(negedge clk);
      check({tag, " R5 overflow one cycle"}, AW'(overflow), 0);
      check({tag, " R5/R8 wr_ptr kept"}, wr_ptr, m_wp);
    end
    check({tag, " R7 avail"}, avail_pkts, f_avail());
  endtask

  task automatic idle_write(input logic [NCH:0] v);
    @(negedge clk);
    idle_wr = 1'b1; idle_wdata = v;
    @(negedge clk);
    idle_wr = 1'b0;
    m_pend = v[NCH] && v[CH];
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 wr_ptr", wr_ptr, 0);
    check("R1 rd_ptr", rd_ptr, 0);
    check("R1 avail", avail_pkts, 0);
    check("R1 wr_stb", AW'(wr_stb), 0);
    check("R1 overflow", AW'(overflow), 0);
    check("R1 idle_ack", AW'(idle_ack), 0);

    // R2 alignment of base
    do_cfg(32'h1234_567F, 32'h1234_5660 + 8 * STR - 1);
    check("R2 aligned wr_ptr", wr_ptr, 32'h1234_5660);
    check("R2 aligned rd_ptr", rd_ptr, 32'h1234_5660);

    // R8 disabled channel
    chan_en = 1'b0; m_en = 1'b0;
    push("R8 disabled");
    chan_en = 1'b1; m_en = 1'b1;

    // Sweep: read position x record count, exact window
    b0 = 32'h0000_1000;
    for (int r = 0; r < 8; r++) begin
      for (int w = 0; w <= 8; w++) begin
        do_cfg(b0, b0 + 8 * STR - 1);
        if (r != 0) wr_rp(b0 + AW'(r * STR));
        for (int k = 0; k < w; k++) push("sweep");
      end
    end

    // R4 wrap, with and without slack above the last record
    for (int s = 0; s < 2; s++) begin
      do_cfg(b0, b0 + 8 * STR + AW'(s * 100) - 1);
      for (int k = 0; k < 7; k++) push("R4 fill");
      push("R5 full");
      wr_rp(b0 + 2 * STR);
      push("R4 wrap");
      check("R4 wrapped to base", wr_ptr, b0);
      check("R7 wrapped avail", avail_pkts, (b0 + 8 * STR + AW'(s * 100) - (b0 + 2 * STR)) / STR);
      push("R4 after wrap");
      wr_rp(m_top + 1);
      check("R6 top+1 folds to base", rd_ptr, b0);
    end

    // R2 abort of a record in progress
    do_cfg(b0, b0 + 8 * STR - 1);
    @(negedge clk); rec_start = 1'b1;
    @(negedge clk); rec_start = 1'b0;
    repeat (5) @(negedge clk);
    cfg_load = 1'b1; cfg_base = 32'h2000; cfg_top = 32'h2000 + 8 * STR - 1;
    @(negedge clk); cfg_load = 1'b0;
    m_base = 32'h2000; m_top = 32'h2000 + 8 * STR - 1; m_wp = m_base; m_rp = m_base;
    check("R2 abort strobe", AW'(wr_stb), 0);
    check("R2 abort wr_ptr", wr_ptr, 32'h2000);

    // R9 / R10 idle handshake
    idle_write(5'b11000);
    check("R9 other channel no ack", AW'(idle_ack), 0);
    idle_write(5'b00100);
    check("R9 flag missing no ack", AW'(idle_ack), 0);
    idle_write(5'b10100);
    check("R9 ack when idle", AW'(idle_ack), 1);
    push("R9 refused while pending");
    check("R9 ack held", AW'(idle_ack), 1);
    idle_write(5'b00000);
    check("R10 cleared", AW'(idle_ack), 0);

    // R9 request during a record
    @(negedge clk); rec_start = 1'b1;
    @(negedge clk); rec_start = 1'b0; idle_wr = 1'b1; idle_wdata = 5'b10100;
    @(negedge clk); idle_wr = 1'b0; m_pend = 1'b1;
    check("R9 no ack during record", AW'(idle_ack), 0);
    repeat (23) @(negedge clk);
    m_wp = adv(m_wp);
    check("R9 record completed", wr_ptr, m_wp);
    check("R9 ack after record", AW'(idle_ack), 1);
    idle_write(5'b00000);
    check("R10 cleared again", AW'(idle_ack), 0);
    push("R10 records resume");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule